// File: doc/BRIEF.md
# Sideband Temperature Sensor Register File

This block is the register side of an emulated remote temperature sensor. An on-chip thermal source delivers fixed-point samples, and a management controller reads them one byte at a time through a simple register port. The block keeps the live temperature, a pair of programmable limits, a sticky status byte and a configuration byte. It drives an active-low alert line whenever a limit has been crossed and alerts are not masked.

A temperature is an unsigned value in eighths of a degree, from 0 to 255.875. The whole degrees sit in one byte and the eighths sit in the top three bits of a second byte. The two bytes are read separately, so the block makes the pair coherent. Reading whichever byte comes first copies the other half into a hold register, and the next read of the second byte returns the held half. A configuration bit chooses which byte is the first one. The serial bus physical layer and address pin strapping sit outside this block.

Top module: `thermal_sideband_regs`

## Requirements
- R1: After reset, reg_rdata is 0x00, alert_n is 1, status reads 0x00, configuration reads 0x00, the high limit reads 0x46 (integer at 0x07) and 0x00 (fraction at 0x13), and the low limit reads 0x00 at both 0x08 and 0x14.
- R2: A sample on temp_in (bits 10:3 whole degrees, bits 2:0 eighths) accepted with temp_valid is readable with the integer at address 0x01 and the eighths in bits 7:5 of address 0x10. For example, the sample 201 reads as 0x19 and 0x20.
- R3: Every fraction byte (0x10, 0x13, 0x14) reads with bits 4:0 zero, and a write to a limit fraction keeps only bits 7:5 of the written data.
- R4: With configuration bit 5 clear, a read of 0x01 copies the live eighths into a hold register, and later reads of 0x10 return that held copy even after new samples arrive.
- R5: With configuration bit 5 set, a read of 0x10 returns the live eighths and copies the live integer into a hold register, and later reads of 0x01 return that held integer.
- R6: Status bit 4 sets when the 11-bit temperature is at or above the 11-bit high limit. It stays set until a status read (address 0x02) happens while the condition no longer holds.
- R7: Status bit 3 sets when the temperature is at or below the low limit, but only once at least one sample has been accepted. It clears under the same sticky rule as bit 4.
- R8: alert_n is 0 exactly when a status bit is set and configuration bit 7 (the alert mask) is clear. With the mask set, alert_n stays 1.
- R9: The configuration byte is written at address 0x09 and read at address 0x03. Only bits 7 and 5 are kept, and the others read as zero.
- R10: Writes to 0x01, 0x02, 0x03, 0x10 and to any unmapped address change nothing. Reads of unmapped addresses, including 0x09, return 0x00.
- R11: A read returns its data on reg_rdata in the cycle after reg_rd, and reg_rdata holds that value otherwise. A limit write affects the status flags from the next clock edge, so alert_n changes two edges after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_in | input | 11 | Temperature sample, unsigned, eighths of a degree |
| temp_valid | input | 1 | Sample strobe |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench runs samples between the two byte reads in both read orders. A design that did not hold the second half would return a torn value that mixes two samples. It also sets the temperature exactly equal to a limit, one eighth below it, and one eighth above it. A comparison that dropped the fraction bits, or used a strict inequality, would miss the equal case or flag the wrong one. Status reads happen both while a condition still holds and after it has gone away, so a flag that cleared too early, or stayed stuck, shows up as a wrong byte. Writes to read-only and unmapped addresses, the alert mask, and the one-cycle lag after a limit write are each observed at the ports.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] ADR_TEMP_WHOLE = 8'h01;
  localparam logic [7:0] ADR_STATUS     = 8'h02;
  localparam logic [7:0] ADR_CFG_VIEW   = 8'h03;
  localparam logic [7:0] ADR_HI_WHOLE   = 8'h07;
  localparam logic [7:0] ADR_LO_WHOLE   = 8'h08;
  localparam logic [7:0] ADR_CFG_SET    = 8'h09;
  localparam logic [7:0] ADR_TEMP_EIGHT = 8'h10;
  localparam logic [7:0] ADR_HI_EIGHT   = 8'h13;
  localparam logic [7:0] ADR_LO_EIGHT   = 8'h14;

  localparam int CFG_ORDER_BIT = 5;
  localparam int CFG_MASK_BIT  = 7;
  localparam int STS_HI_BIT    = 4;
  localparam int STS_LO_BIT    = 3;
  localparam logic [7:0] CFG_KEEP = 8'hA0;
endpackage

// File: rtl/tsr_limit_regs.sv
module tsr_limit_regs
  import tsr_pkg::*;
#(
  parameter int FRAC_W = 3,
  parameter int LIM_W  = 11,
  parameter logic [LIM_W-1:0] HI_INIT = 11'd560,
  parameter logic [LIM_W-1:0] LO_INIT = 11'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic [LIM_W-1:0]  hi_lim,
  output logic [LIM_W-1:0]  lo_lim,
  output logic [7:0]        cfg
);
  logic known_dst;

  always_comb begin
    case (addr)
      ADR_HI_WHOLE, ADR_LO_WHOLE, ADR_HI_EIGHT, ADR_LO_EIGHT, ADR_CFG_SET: known_dst = 1'b1;
      default: known_dst = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_lim <= HI_INIT;
      lo_lim <= LO_INIT;
      cfg    <= '0;
    end else if (we) begin
      case (addr)
        ADR_HI_WHOLE: hi_lim[LIM_W-1:FRAC_W] <= wdata[LIM_W-FRAC_W-1:0];
        ADR_LO_WHOLE: lo_lim[LIM_W-1:FRAC_W] <= wdata[LIM_W-FRAC_W-1:0];
        ADR_HI_EIGHT: hi_lim[FRAC_W-1:0]     <= wdata[BYTE_W-1 -: FRAC_W];
        ADR_LO_EIGHT: lo_lim[FRAC_W-1:0]     <= wdata[BYTE_W-1 -: FRAC_W];
        ADR_CFG_SET:  cfg                    <= wdata & CFG_KEEP;
        default: ;
      endcase
    end
  end

  assert_ro_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (we && !known_dst) |=> ($stable(hi_lim) && $stable(lo_lim) && $stable(cfg)));

  assert_cfg_bits_R9: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADR_CFG_SET) |=> (cfg == ($past(wdata) & CFG_KEEP)));
endmodule

// File: rtl/tsr_read_latch.sv
module tsr_read_latch #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 3,
  parameter int LIM_W  = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LIM_W-1:0]  temp_in,
  input  logic              temp_valid,
  input  logic              rd_whole,
  input  logic              rd_eighth,
  input  logic              order_frac_first,
  output logic [LIM_W-1:0]  live,
  output logic              seen,
  output logic [INT_W-1:0]  whole_view,
  output logic [FRAC_W-1:0] eighth_view
);
  logic [INT_W-1:0]  held_whole;
  logic [FRAC_W-1:0] held_eighth;

  always_ff @(posedge clk) begin
    if (rst) begin
      live        <= '0;
      seen        <= 1'b0;
      held_whole  <= '0;
      held_eighth <= '0;
    end else begin
      if (rd_whole && !order_frac_first)
        held_eighth <= live[FRAC_W-1:0];
      if (rd_eighth && order_frac_first)
        held_whole <= live[LIM_W-1:FRAC_W];
      if (temp_valid) begin
        live <= temp_in;
        seen <= 1'b1;
      end
    end
  end

  assign whole_view  = order_frac_first ? held_whole : live[LIM_W-1:FRAC_W];
  assign eighth_view = order_frac_first ? live[FRAC_W-1:0] : held_eighth;

  assert_hold_eighth_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_whole && !order_frac_first) |=> (held_eighth == $past(live[FRAC_W-1:0])));

  assert_hold_whole_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_eighth && order_frac_first) |=> (held_whole == $past(live[LIM_W-1:FRAC_W])));

  assert_sample_take_R2: assert property (@(posedge clk) disable iff (rst)
    temp_valid |=> (live == $past(temp_in) && seen));
endmodule

// File: rtl/tsr_alert_status.sv
module tsr_alert_status #(
  parameter int LIM_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LIM_W-1:0] temp,
  input  logic             seen,
  input  logic [LIM_W-1:0] hi_lim,
  input  logic [LIM_W-1:0] lo_lim,
  input  logic             status_rd,
  input  logic             mask,
  output logic             flag_hi,
  output logic             flag_lo,
  output logic             alert_n
);
  logic hot_now, cold_now, hi_nxt, lo_nxt;

  always_comb begin
    hot_now  = seen && (temp >= hi_lim);
    cold_now = seen && (temp <= lo_lim);
    hi_nxt   = hot_now  || (flag_hi && !status_rd);
    lo_nxt   = cold_now || (flag_lo && !status_rd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
      alert_n <= 1'b1;
    end else begin
      flag_hi <= hi_nxt;
      flag_lo <= lo_nxt;
      alert_n <= !((hi_nxt || lo_nxt) && !mask);
    end
  end

  assert_hi_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_hi && !status_rd) |=> flag_hi);

  assert_lo_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_lo && !status_rd) |=> flag_lo);

  assert_no_flag_unseen_R7: assert property (@(posedge clk) disable iff (rst)
    !seen |-> (!flag_hi && !flag_lo));

  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    mask |=> alert_n);

  assert_alert_cause_R8: assert property (@(posedge clk) disable iff (rst)
    !alert_n |-> (flag_hi || flag_lo));
endmodule

// File: rtl/thermal_sideband_regs.sv
module thermal_sideband_regs
  import tsr_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 3,
  parameter int HI_INIT_DEG = 70,
  parameter int LO_INIT_DEG = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [INT_W+FRAC_W-1:0] temp_in,
  input  logic                    temp_valid,
  input  logic [7:0]              reg_addr,
  input  logic                    reg_we,
  input  logic [7:0]              reg_wdata,
  input  logic                    reg_rd,
  output logic [7:0]              reg_rdata,
  output logic                    alert_n
);
  localparam int LIM_W = INT_W + FRAC_W;
  localparam logic [LIM_W-1:0] HI_INIT = LIM_W'(HI_INIT_DEG << FRAC_W);
  localparam logic [LIM_W-1:0] LO_INIT = LIM_W'(LO_INIT_DEG << FRAC_W);
  localparam int PAD_W = BYTE_W - FRAC_W;

  logic [LIM_W-1:0]  hi_lim, lo_lim, live;
  logic [7:0]        cfg;
  logic              seen, flag_hi, flag_lo;
  logic [INT_W-1:0]  whole_view;
  logic [FRAC_W-1:0] eighth_view;
  logic              rd_whole, rd_eighth, rd_status;
  logic [7:0]        rd_mux;

  assign rd_whole  = reg_rd && (reg_addr == ADR_TEMP_WHOLE);
  assign rd_eighth = reg_rd && (reg_addr == ADR_TEMP_EIGHT);
  assign rd_status = reg_rd && (reg_addr == ADR_STATUS);

  tsr_limit_regs #(.FRAC_W(FRAC_W), .LIM_W(LIM_W), .HI_INIT(HI_INIT), .LO_INIT(LO_INIT)) u_limits (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .cfg(cfg)
  );

  tsr_read_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LIM_W(LIM_W)) u_latch (
    .clk(clk), .rst(rst), .temp_in(temp_in), .temp_valid(temp_valid),
    .rd_whole(rd_whole), .rd_eighth(rd_eighth), .order_frac_first(cfg[CFG_ORDER_BIT]),
    .live(live), .seen(seen), .whole_view(whole_view), .eighth_view(eighth_view)
  );

  tsr_alert_status #(.LIM_W(LIM_W)) u_status (
    .clk(clk), .rst(rst), .temp(live), .seen(seen), .hi_lim(hi_lim), .lo_lim(lo_lim),
    .status_rd(rd_status), .mask(cfg[CFG_MASK_BIT]),
    .flag_hi(flag_hi), .flag_lo(flag_lo), .alert_n(alert_n)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADR_TEMP_WHOLE: rd_mux = BYTE_W'(whole_view);
      ADR_STATUS: begin
        rd_mux[STS_HI_BIT] = flag_hi;
        rd_mux[STS_LO_BIT] = flag_lo;
      end
      ADR_CFG_VIEW:   rd_mux = cfg;
      ADR_HI_WHOLE:   rd_mux = BYTE_W'(hi_lim[LIM_W-1:FRAC_W]);
      ADR_LO_WHOLE:   rd_mux = BYTE_W'(lo_lim[LIM_W-1:FRAC_W]);
      ADR_TEMP_EIGHT: rd_mux = {eighth_view, {PAD_W{1'b0}}};
      ADR_HI_EIGHT:   rd_mux = {hi_lim[FRAC_W-1:0], {PAD_W{1'b0}}};
      ADR_LO_EIGHT:   rd_mux = {lo_lim[FRAC_W-1:0], {PAD_W{1'b0}}};
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end

  assert_eighth_pad_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (reg_addr == ADR_TEMP_EIGHT || reg_addr == ADR_HI_EIGHT || reg_addr == ADR_LO_EIGHT))
    |=> (reg_rdata[PAD_W-1:0] == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/thermal_sideband_regs_test.sv
`timescale 1ns/1ps
module thermal_sideband_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] temp_in = '0;
  logic        temp_valid = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        alert_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  thermal_sideband_regs uut (
    .clk(clk), .rst(rst), .temp_in(temp_in), .temp_valid(temp_valid),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .alert_n(alert_n)
  );

  // behavioural reference, advanced on every rising edge
  int   m_temp, m_hi, m_lo, m_shf, m_shi, m_rd;
  bit   m_seen, m_fh, m_fl, m_al, m_live;
  logic [7:0] m_cfg;

  always @(posedge clk) begin
    bit hc, lc, clr, nh, nl;
    if (rst) begin
      m_temp = 0; m_seen = 0; m_hi = 560; m_lo = 0; m_cfg = 8'h00;
      m_shf = 0; m_shi = 0; m_fh = 0; m_fl = 0; m_rd = 0; m_al = 1; m_live = 1;
    end else begin
      hc  = m_seen && (m_temp >= m_hi);
      lc  = m_seen && (m_temp <= m_lo);
      clr = reg_rd && reg_addr == 8'h02;
      nh  = hc || (m_fh && !clr);
      nl  = lc || (m_fl && !clr);
      if (reg_rd) begin
        case (reg_addr)
          8'h01: m_rd = m_cfg[5] ? m_shi : m_temp / 8;
          8'h02: m_rd = (m_fh ? 16 : 0) + (m_fl ? 8 : 0);
          8'h03: m_rd = m_cfg;
          8'h07: m_rd = m_hi / 8;
          8'h08: m_rd = m_lo / 8;
          8'h10: m_rd = (m_cfg[5] ? m_temp % 8 : m_shf) * 32;
          8'h13: m_rd = (m_hi % 8) * 32;
          8'h14: m_rd = (m_lo % 8) * 32;
          default: m_rd = 0;
        endcase
      end
      m_al = !((nh || nl) && !m_cfg[7]);
      if (reg_rd && reg_addr == 8'h01 && !m_cfg[5]) m_shf = m_temp % 8;
      if (reg_rd && reg_addr == 8'h10 && m_cfg[5])  m_shi = m_temp / 8;
      if (reg_we) begin
        case (reg_addr)
          8'h07: m_hi = reg_wdata * 8 + m_hi % 8;
          8'h08: m_lo = reg_wdata * 8 + m_lo % 8;
          8'h13: m_hi = (m_hi / 8) * 8 + reg_wdata / 32;
          8'h14: m_lo = (m_lo / 8) * 8 + reg_wdata / 32;
          8'h09: m_cfg = reg_wdata & 8'hA0;
          default: ;
        endcase
      end
      if (temp_valid) begin m_temp = temp_in; m_seen = 1; end
      m_fh = nh; m_fl = nl;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R11 timing, R8 alert)
  always @(negedge clk) begin
    if (m_live && !rst) begin
      chk("R11 model rdata", reg_rdata, m_rd);
      chk("R8 model alert_n", alert_n, m_al);
    end
  end

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic sample(input int t);
    @(negedge clk); temp_in = 11'(t); temp_valid = 1'b1;
    @(negedge clk); temp_valid = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input int exp);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 alert_n", alert_n, 1);
    rchk("R1 hi whole", 8'h07, 8'h46);
    rchk("R1 hi eighth", 8'h13, 8'h00);
    rchk("R1 lo whole", 8'h08, 8'h00);
    rchk("R1 lo eighth", 8'h14, 8'h00);
    rchk("R1 status", 8'h02, 8'h00);
    rchk("R1 config", 8'h03, 8'h00);
    // R2 format 25.125
    sample(201);
    rchk("R2 whole", 8'h01, 8'h19);
    rchk("R2 eighth", 8'h10, 8'h20);
    // R4 held eighth across a new sample
    rchk("R4 whole first", 8'h01, 8'h19);
    sample(244);
    rchk("R4 held eighth", 8'h10, 8'h20);
    rchk("R4 new whole", 8'h01, 8'h1E);
    rchk("R4 new eighth", 8'h10, 8'h80);
    // R7 low limit
    wr(8'h08, 8'h20);
    rchk("R7 low set", 8'h02, 8'h08);
    chk("R7 alert", alert_n, 0);
    wr(8'h08, 8'h00);
    rchk("R7 sticky", 8'h02, 8'h08);
    rchk("R7 cleared", 8'h02, 8'h00);
    chk("R8 alert idle", alert_n, 1);
    // R6 high limit, equal boundary then one eighth above
    wr(8'h07, 8'h1E);
    wr(8'h13, 8'h80);
    rchk("R6 equal sets", 8'h02, 8'h10);
    wr(8'h13, 8'hA0);
    rchk("R6 sticky", 8'h02, 8'h10);
    rchk("R6 cleared", 8'h02, 8'h00);
    // R3 fraction write keeps top bits
    wr(8'h13, 8'hFF);
    rchk("R3 eighth pad", 8'h13, 8'hE0);
    // R11 limit write lag
    @(negedge clk); reg_addr = 8'h07; reg_wdata = 8'h10; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    chk("R11 alert not yet", alert_n, 1);
    @(negedge clk);
    chk("R11 alert next", alert_n, 0);
    wr(8'h07, 8'h46);
    rchk("R11 status", 8'h02, 8'h10);
    rchk("R11 status clear", 8'h02, 8'h00);
    // R9 / R8 mask
    wr(8'h09, 8'hFF);
    rchk("R9 config", 8'h03, 8'hA0);
    wr(8'h07, 8'h10);
    @(negedge clk);
    chk("R8 masked", alert_n, 1);
    wr(8'h09, 8'h20);
    @(negedge clk);
    chk("R8 unmasked", alert_n, 0);
    wr(8'h07, 8'h46);
    rchk("R8 status", 8'h02, 8'h10);
    rchk("R8 clear", 8'h02, 8'h00);
    // R5 eighth-first order
    sample(201);
    rchk("R5 eighth live", 8'h10, 8'h20);
    sample(320);
    rchk("R5 held whole", 8'h01, 8'h19);
    rchk("R5 new eighth", 8'h10, 8'h00);
    rchk("R5 new whole", 8'h01, 8'h28);
    // R10 ignored writes and unmapped reads
    wr(8'h03, 8'hFF);
    wr(8'h02, 8'hFF);
    wr(8'h01, 8'h77);
    wr(8'h10, 8'hFF);
    wr(8'h30, 8'h55);
    rchk("R10 config kept", 8'h03, 8'h20);
    rchk("R10 hi kept", 8'h07, 8'h46);
    rchk("R10 lo kept", 8'h08, 8'h00);
    rchk("R10 whole kept", 8'h01, 8'h28);
    rchk("R10 eighth kept", 8'h10, 8'h00);
    rchk("R10 status", 8'h02, 8'h00);
    rchk("R10 unmapped", 8'h30, 8'h00);
    rchk("R10 cfg alias", 8'h09, 8'h00);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule